// File: doc/BRIEF.md
# Floating-Point Special-Operand Resolver

This block sits in front of a single-precision arithmetic unit and decides, from the raw binary32 operands alone, whether an add, subtract, multiply, fused multiply-add or fused multiply-subtract has a result that needs no arithmetic. If any operand is a NaN, if an infinity meets a zero in a product, or if an infinity is involved at all, the block produces the final value and tells the datapath to use it. For the multiply-add forms the first operand is the accumulator and the second and third form the product (result = A + B*C, or A - B*C). For the two-operand forms the third operand is ignored.

Two NaN policies can be selected with one input. The standard policy quiets any signaling NaN it returns, raises the invalid flag when a signaling NaN is present, and uses one operand order. The legacy policy passes NaNs through bit-for-bit, uses a different operand order and never raises the flag. The block holds no state and its outputs follow its inputs in the same cycle.

Top module: `fpsr_special_resolve`

## Requirements
- R1: When no special case applies (all operands that take part are finite and not NaN), `bypass_o` is 0, `result_o` is 0 and `invalid_o` is 0.
- R2: `op_i` encodes 0 = add, 1 = subtract, 2 = multiply, 3 = multiply-add, 4 = multiply-subtract; codes 5, 6 and 7 never assert any output. `legacy_i` = 0 picks the standard policy, 1 the legacy policy.
- R3: Standard policy, add/subtract/multiply: a NaN in operand B is returned if present, otherwise the NaN in A; the returned value has bit 22 set; `invalid_o` is 1 exactly when A or B is a signaling NaN (exponent all ones, bit 22 clear, fraction nonzero).
- R4: Legacy policy, add/subtract/multiply: the NaN in A is returned if present, otherwise the one in B, unchanged, with `invalid_o` = 0.
- R5: Standard policy, multiply-add and multiply-subtract: the NaN is chosen in the order A, then C, then B, returned with bit 22 set; `invalid_o` is 1 if any operand is a signaling NaN or the product is infinity times zero.
- R6: Legacy policy, multiply-add and multiply-subtract: the NaN is chosen in the order B, then C, then A, and returned unchanged, even when the product is infinity times zero.
- R7: Add or subtract of two infinities whose effective signs differ returns 0x7FC00000, with `invalid_o` = 1 in the standard policy.
- R8: Add or subtract with one infinity and no NaN returns that infinity (negated when it is the subtrahend), with `invalid_o` = 0.
- R9: Infinity times zero (either zero sign) in a multiply, or in the product of a multiply-add/subtract with a non-NaN accumulator, returns 0x7FC00000; `invalid_o` = 1 only in the standard policy.
- R10: In the legacy policy `invalid_o` is always 0.
- R11: An infinite product (sign = XOR of factor signs, inverted for multiply-subtract) is returned when the accumulator is finite or has the same sign; if the accumulator is an infinity of the other sign the result is 0x7FC00000 with `invalid_o` = 1 in the standard policy. A multiply with one infinite and one finite nonzero factor returns the signed infinity.
- R12: For add, subtract and multiply, operand C has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code (see R2) |
| legacy_i | input | 1 | NaN policy select: 0 standard, 1 legacy |
| opnd_a_i | input | 32 | Operand A (first addend / accumulator) |
| opnd_b_i | input | 32 | Operand B (second addend / multiplicand) |
| opnd_c_i | input | 32 | Operand C (multiplier of the fused forms) |
| bypass_o | output | 1 | Result is special and replaces the datapath result |
| result_o | output | 32 | Special result, 0 when `bypass_o` is 0 |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
Every output is a pure function of the current inputs, so each result is due in the same cycle as its stimulus, zero clock edges later. The bench changes the inputs on the falling clock edge and samples the outputs one nanosecond afterwards, well before the next rising edge, so no check depends on register timing or process ordering. The stimulus table covers each NaN ordering of both policies, signaling versus quiet payloads, and every infinity combination named in the requirements, and directed loops sweep unused opcodes and the legacy flag across all operations.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int DATA_W  = 1 + EXP_W + FRAC_W;
  localparam int QBIT    = FRAC_W - 1;
  localparam int NUM_OPS = 3;

  typedef enum logic [2:0] {
    FOP_ADD  = 3'd0,
    FOP_SUB  = 3'd1,
    FOP_MUL  = 3'd2,
    FOP_MADD = 3'd3,
    FOP_MSUB = 3'd4
  } fop_e;

  function automatic logic exp_all_ones(input logic [DATA_W-1:0] x);
    return &x[DATA_W-2 -: EXP_W];
  endfunction

  function automatic logic frac_nonzero(input logic [DATA_W-1:0] x);
    return |x[FRAC_W-1:0];
  endfunction

  function automatic logic is_nan(input logic [DATA_W-1:0] x);
    return exp_all_ones(x) & frac_nonzero(x);
  endfunction

  function automatic logic is_snan(input logic [DATA_W-1:0] x);
    return is_nan(x) & ~x[QBIT];
  endfunction

  function automatic logic is_inf(input logic [DATA_W-1:0] x);
    return exp_all_ones(x) & ~frac_nonzero(x);
  endfunction

  function automatic logic is_zero(input logic [DATA_W-1:0] x);
    return ~|x[DATA_W-2:0];
  endfunction

  function automatic logic [DATA_W-1:0] quieten(input logic [DATA_W-1:0] x);
    logic [DATA_W-1:0] y;
    y       = x;
    y[QBIT] = 1'b1;
    return y;
  endfunction

  function automatic logic [DATA_W-1:0] default_nan();
    logic [DATA_W-1:0] y;
    y                       = '0;
    y[DATA_W-2 -: EXP_W]    = '1;
    y[QBIT]                 = 1'b1;
    return y;
  endfunction

  function automatic logic [DATA_W-1:0] signed_inf(input logic s);
    logic [DATA_W-1:0] y;
    y                    = '0;
    y[DATA_W-1]          = s;
    y[DATA_W-2 -: EXP_W] = '1;
    return y;
  endfunction

endpackage

// File: rtl/fpsr_classify.sv
module fpsr_classify
  import fpsr_pkg::*;
(
  input  logic [DATA_W-1:0] val_i,
  output logic              nan_o,
  output logic              snan_o,
  output logic              inf_o,
  output logic              zero_o,
  output logic              sign_o
);
  assign nan_o  = is_nan(val_i);
  assign snan_o = is_snan(val_i);
  assign inf_o  = is_inf(val_i);
  assign zero_o = is_zero(val_i);
  assign sign_o = val_i[DATA_W-1];
endmodule

// File: rtl/fpsr_nan_pick.sv
module fpsr_nan_pick
  import fpsr_pkg::*;
(
  input  logic [DATA_W-1:0]  opnd_i [NUM_OPS],
  input  logic [NUM_OPS-1:0] nan_i,
  input  logic [NUM_OPS-1:0] snan_i,
  input  logic               three_op_i,
  input  logic               legacy_i,
  output logic               found_o,
  output logic               any_snan_o,
  output logic [DATA_W-1:0]  pick_o
);
  localparam int IDX_W = $clog2(NUM_OPS);

  logic [IDX_W-1:0]   ord [NUM_OPS];
  logic [NUM_OPS-1:0] live;

  // priority order per policy and operand count
  always_comb begin
    case ({three_op_i, legacy_i})
      2'b00:   begin ord[0] = 2'd1; ord[1] = 2'd0; ord[2] = 2'd2; end
      2'b01:   begin ord[0] = 2'd0; ord[1] = 2'd1; ord[2] = 2'd2; end
      2'b10:   begin ord[0] = 2'd0; ord[1] = 2'd2; ord[2] = 2'd1; end
      default: begin ord[0] = 2'd1; ord[1] = 2'd2; ord[2] = 2'd0; end
    endcase
  end

  always_comb begin
    live = '1;
    live[NUM_OPS-1] = three_op_i;
  end

  assign any_snan_o = |(snan_i & live);

  always_comb begin
    found_o = 1'b0;
    pick_o  = '0;
    for (int k = 0; k < NUM_OPS; k++) begin
      if (!found_o && nan_i[ord[k]] && live[ord[k]]) begin
        found_o = 1'b1;
        pick_o  = opnd_i[ord[k]];
      end
    end
  end
endmodule

// File: rtl/fpsr_inf_resolve.sv
module fpsr_inf_resolve
  import fpsr_pkg::*;
(
  input  logic [2:0]         op_i,
  input  logic [NUM_OPS-1:0] inf_i,
  input  logic [NUM_OPS-1:0] zero_i,
  input  logic [NUM_OPS-1:0] sign_i,
  output logic               inf_zero_o,
  output logic               inf_clash_o,
  output logic               inf_hit_o,
  output logic [DATA_W-1:0]  inf_val_o
);
  logic is_sub, is_mul, is_fused, negate_prod;
  logic b_eff_sign, prod_sign, prod_inf, two_inf_zero, fused_inf_zero;

  assign is_sub      = (op_i == FOP_SUB);
  assign is_mul      = (op_i == FOP_MUL);
  assign is_fused    = (op_i == FOP_MADD) || (op_i == FOP_MSUB);
  assign negate_prod = (op_i == FOP_MSUB);

  assign b_eff_sign     = sign_i[1] ^ is_sub;
  assign two_inf_zero   = (inf_i[0] & zero_i[1]) | (zero_i[0] & inf_i[1]);
  assign fused_inf_zero = (inf_i[1] & zero_i[2]) | (zero_i[1] & inf_i[2]);
  assign prod_inf       = inf_i[1] | inf_i[2];
  assign prod_sign      = sign_i[1] ^ sign_i[2] ^ negate_prod;

  always_comb begin
    inf_zero_o  = 1'b0;
    inf_clash_o = 1'b0;
    inf_hit_o   = 1'b0;
    inf_val_o   = '0;
    if (is_fused) begin
      if (fused_inf_zero) begin
        inf_zero_o = 1'b1;
      end else if (prod_inf && inf_i[0] && (sign_i[0] != prod_sign)) begin
        inf_clash_o = 1'b1;
      end else if (prod_inf) begin
        inf_hit_o = 1'b1;
        inf_val_o = signed_inf(prod_sign);
      end else if (inf_i[0]) begin
        inf_hit_o = 1'b1;
        inf_val_o = signed_inf(sign_i[0]);
      end
    end else if (is_mul) begin
      if (two_inf_zero) begin
        inf_zero_o = 1'b1;
      end else if (inf_i[0] || inf_i[1]) begin
        inf_hit_o = 1'b1;
        inf_val_o = signed_inf(sign_i[0] ^ sign_i[1]);
      end
    end else begin
      if (inf_i[0] && inf_i[1] && (sign_i[0] != b_eff_sign)) begin
        inf_clash_o = 1'b1;
      end else if (inf_i[0]) begin
        inf_hit_o = 1'b1;
        inf_val_o = signed_inf(sign_i[0]);
      end else if (inf_i[1]) begin
        inf_hit_o = 1'b1;
        inf_val_o = signed_inf(b_eff_sign);
      end
    end
  end
endmodule

// File: rtl/fpsr_special_resolve.sv
module fpsr_special_resolve
  import fpsr_pkg::*;
(
  input  logic [2:0]        op_i,
  input  logic              legacy_i,
  input  logic [DATA_W-1:0] opnd_a_i,
  input  logic [DATA_W-1:0] opnd_b_i,
  input  logic [DATA_W-1:0] opnd_c_i,
  output logic              bypass_o,
  output logic [DATA_W-1:0] result_o,
  output logic              invalid_o
);
  logic [DATA_W-1:0]  opnd [NUM_OPS];
  logic [NUM_OPS-1:0] nan_v, snan_v, inf_v, zero_v, sign_v;

  logic              op_valid_w, three_op_w;
  logic              any_nan_w, any_snan_w;
  logic [DATA_W-1:0] nan_pick_w;
  logic              inf_zero_w, inf_clash_w, inf_hit_w;
  logic [DATA_W-1:0] inf_val_w;

  assign opnd[0] = opnd_a_i;
  assign opnd[1] = opnd_b_i;
  assign opnd[2] = opnd_c_i;

  assign op_valid_w = (op_i <= FOP_MSUB);
  assign three_op_w = (op_i == FOP_MADD) || (op_i == FOP_MSUB);

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
    fpsr_classify u_cls (
      .val_i  (opnd[g]),
      .nan_o  (nan_v[g]),
      .snan_o (snan_v[g]),
      .inf_o  (inf_v[g]),
      .zero_o (zero_v[g]),
      .sign_o (sign_v[g])
    );
  end

  fpsr_nan_pick u_pick (
    .opnd_i     (opnd),
    .nan_i      (nan_v),
    .snan_i     (snan_v),
    .three_op_i (three_op_w),
    .legacy_i   (legacy_i),
    .found_o    (any_nan_w),
    .any_snan_o (any_snan_w),
    .pick_o     (nan_pick_w)
  );

  fpsr_inf_resolve u_inf (
    .op_i        (op_i),
    .inf_i       (inf_v),
    .zero_i      (zero_v),
    .sign_i      (sign_v),
    .inf_zero_o  (inf_zero_w),
    .inf_clash_o (inf_clash_w),
    .inf_hit_o   (inf_hit_w),
    .inf_val_o   (inf_val_w)
  );

  always_comb begin
    bypass_o  = 1'b0;
    result_o  = '0;
    invalid_o = 1'b0;
    if (op_valid_w) begin
      if (any_nan_w) begin
        bypass_o  = 1'b1;
        result_o  = legacy_i ? nan_pick_w : quieten(nan_pick_w);
        invalid_o = !legacy_i && (any_snan_w || inf_zero_w);
      end else if (inf_zero_w || inf_clash_w) begin
        bypass_o  = 1'b1;
        result_o  = default_nan();
        invalid_o = !legacy_i;
      end else if (inf_hit_w) begin
        bypass_o  = 1'b1;
        result_o  = inf_val_w;
      end
    end
  end
endmodule

// File: rtl/fpsr_special_resolve_chk.sv
module fpsr_special_resolve_chk
  import fpsr_pkg::*;
(
  input logic              legacy_i,
  input logic              bypass_o,
  input logic [DATA_W-1:0] result_o,
  input logic              invalid_o,
  input logic              op_valid_w,
  input logic              any_nan_w,
  input logic              inf_zero_w,
  input logic              inf_clash_w
);
  always_comb begin
    // R1
    idle_outputs_zero_chk: assert (bypass_o || (result_o == '0 && !invalid_o))
      else $error("outputs nonzero without bypass");
    // R10
    legacy_no_flag_chk: assert (!legacy_i || !invalid_o)
      else $error("invalid raised in legacy policy");
    // R3
    std_nan_quiet_chk: assert (!(op_valid_w && any_nan_w && !legacy_i) ||
                               (bypass_o && result_o[QBIT] && is_nan(result_o)))
      else $error("standard policy returned a non-quiet NaN");
    // R9
    inf_zero_dnan_chk: assert (!(op_valid_w && inf_zero_w && !any_nan_w) ||
                               (bypass_o && result_o == default_nan()))
      else $error("infinity times zero did not give default NaN");
    // R7
    clash_invalid_chk: assert (!(op_valid_w && inf_clash_w && !any_nan_w && !legacy_i) ||
                               invalid_o)
      else $error("infinity clash without invalid flag");
  end
endmodule

bind fpsr_special_resolve fpsr_special_resolve_chk u_chk (
  .legacy_i    (legacy_i),
  .bypass_o    (bypass_o),
  .result_o    (result_o),
  .invalid_o   (invalid_o),
  .op_valid_w  (op_valid_w),
  .any_nan_w   (any_nan_w),
  .inf_zero_w  (inf_zero_w),
  .inf_clash_w (inf_clash_w)
);

// File: tb/tb_fpsr_special_resolve.sv
module tb_fpsr_special_resolve;

  localparam logic [31:0] ZERO = 32'h0000_0000;
  localparam logic [31:0] ONE  = 32'h3F80_0000;
  localparam logic [31:0] NONE = 32'hBF80_0000;
  localparam logic [31:0] F15  = 32'h3FC0_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000;
  localparam logic [31:0] NINF = 32'hFF80_0000;
  localparam logic [31:0] DNAN = 32'h7FC0_0000;
  localparam logic [31:0] Q1   = 32'h7FC0_0001;
  localparam logic [31:0] Q2   = 32'h7FC0_0002;
  localparam logic [31:0] Q3   = 32'h7FC0_0003;
  localparam logic [31:0] S1   = 32'h7F80_0001;
  localparam logic [31:0] S2   = 32'h7FBF_FFFF;
  localparam logic [31:0] QS2  = 32'h7FFF_FFFF;

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic        leg;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] c;
    logic        byp;
    logic [31:0] res;
    logic        inv;
  } vec_t;

  localparam int NV = 51;
  // op: 0 add, 1 sub, 2 mul, 3 madd, 4 msub
  localparam vec_t VECS [NV] = '{
    '{4'd1,  3'd0, 1'b0, F15,  ONE,  ZERO, 1'b0, ZERO, 1'b0}, // R1
    '{4'd1,  3'd3, 1'b0, ONE,  ONE,  ONE,  1'b0, ZERO, 1'b0}, // R1
    '{4'd2,  3'd5, 1'b0, PINF, NINF, S1,   1'b0, ZERO, 1'b0}, // R2
    '{4'd3,  3'd0, 1'b0, ONE,  Q1,   ZERO, 1'b1, Q1,   1'b0}, // R3
    '{4'd3,  3'd0, 1'b0, ONE,  S1,   ZERO, 1'b1, Q1,   1'b1}, // R3
    '{4'd3,  3'd0, 1'b0, S1,   S2,   ZERO, 1'b1, QS2,  1'b1}, // R3
    '{4'd3,  3'd0, 1'b0, S2,   S1,   ZERO, 1'b1, Q1,   1'b1}, // R3
    '{4'd3,  3'd1, 1'b0, Q1,   S2,   ZERO, 1'b1, QS2,  1'b1}, // R3
    '{4'd3,  3'd1, 1'b0, S2,   Q1,   ZERO, 1'b1, Q1,   1'b1}, // R3
    '{4'd3,  3'd2, 1'b0, Q1,   Q2,   ZERO, 1'b1, Q2,   1'b0}, // R3
    '{4'd4,  3'd0, 1'b1, S1,   S2,   ZERO, 1'b1, S1,   1'b0}, // R4
    '{4'd4,  3'd0, 1'b1, S2,   S1,   ZERO, 1'b1, S2,   1'b0}, // R4
    '{4'd4,  3'd1, 1'b1, Q1,   S2,   ZERO, 1'b1, Q1,   1'b0}, // R4
    '{4'd4,  3'd0, 1'b1, ONE,  S1,   ZERO, 1'b1, S1,   1'b0}, // R4
    '{4'd4,  3'd2, 1'b1, Q1,   Q2,   ZERO, 1'b1, Q1,   1'b0}, // R4
    '{4'd7,  3'd0, 1'b0, PINF, NINF, ZERO, 1'b1, DNAN, 1'b1}, // R7
    '{4'd7,  3'd1, 1'b0, PINF, PINF, ZERO, 1'b1, DNAN, 1'b1}, // R7
    '{4'd7,  3'd0, 1'b1, PINF, NINF, ZERO, 1'b1, DNAN, 1'b0}, // R7
    '{4'd8,  3'd0, 1'b0, F15,  PINF, ZERO, 1'b1, PINF, 1'b0}, // R8
    '{4'd8,  3'd1, 1'b0, ONE,  PINF, ZERO, 1'b1, NINF, 1'b0}, // R8
    '{4'd8,  3'd1, 1'b0, PINF, NINF, ZERO, 1'b1, PINF, 1'b0}, // R8
    '{4'd8,  3'd0, 1'b0, NINF, ONE,  ZERO, 1'b1, NINF, 1'b0}, // R8
    '{4'd9,  3'd2, 1'b0, PINF, ZERO, ZERO, 1'b1, DNAN, 1'b1}, // R9
    '{4'd9,  3'd2, 1'b1, ZERO, NINF, ZERO, 1'b1, DNAN, 1'b0}, // R9
    '{4'd9,  3'd3, 1'b0, ONE,  PINF, ZERO, 1'b1, DNAN, 1'b1}, // R9
    '{4'd9,  3'd3, 1'b1, ONE,  PINF, ZERO, 1'b1, DNAN, 1'b0}, // R9
    '{4'd5,  3'd3, 1'b0, Q1,   ONE,  ONE,  1'b1, Q1,   1'b0}, // R5
    '{4'd5,  3'd3, 1'b0, ONE,  Q2,   ONE,  1'b1, Q2,   1'b0}, // R5
    '{4'd5,  3'd3, 1'b0, ONE,  ONE,  Q3,   1'b1, Q3,   1'b0}, // R5
    '{4'd5,  3'd3, 1'b0, Q1,   Q2,   ONE,  1'b1, Q1,   1'b0}, // R5
    '{4'd5,  3'd3, 1'b0, ONE,  Q2,   Q3,   1'b1, Q3,   1'b0}, // R5
    '{4'd5,  3'd3, 1'b0, Q1,   Q2,   Q3,   1'b1, Q1,   1'b0}, // R5
    '{4'd5,  3'd3, 1'b0, S1,   PINF, ZERO, 1'b1, Q1,   1'b1}, // R5
    '{4'd5,  3'd3, 1'b0, Q1,   PINF, ZERO, 1'b1, Q1,   1'b1}, // R5
    '{4'd5,  3'd3, 1'b0, S1,   ONE,  ONE,  1'b1, Q1,   1'b1}, // R5
    '{4'd5,  3'd3, 1'b0, Q1,   S2,   ONE,  1'b1, Q1,   1'b1}, // R5
    '{4'd6,  3'd3, 1'b1, Q1,   Q2,   ONE,  1'b1, Q2,   1'b0}, // R6
    '{4'd6,  3'd3, 1'b1, Q1,   ONE,  Q3,   1'b1, Q3,   1'b0}, // R6
    '{4'd6,  3'd3, 1'b1, Q1,   Q2,   Q3,   1'b1, Q2,   1'b0}, // R6
    '{4'd6,  3'd3, 1'b1, S1,   PINF, ZERO, 1'b1, S1,   1'b0}, // R6
    '{4'd6,  3'd3, 1'b1, Q1,   S2,   ONE,  1'b1, S2,   1'b0}, // R6
    '{4'd6,  3'd4, 1'b1, Q1,   ONE,  Q3,   1'b1, Q3,   1'b0}, // R6
    '{4'd5,  3'd4, 1'b0, Q1,   Q2,   Q3,   1'b1, Q1,   1'b0}, // R5
    '{4'd11, 3'd2, 1'b0, PINF, NONE, ZERO, 1'b1, NINF, 1'b0}, // R11
    '{4'd11, 3'd3, 1'b0, PINF, PINF, ONE,  1'b1, PINF, 1'b0}, // R11
    '{4'd11, 3'd4, 1'b0, PINF, PINF, ONE,  1'b1, DNAN, 1'b1}, // R11
    '{4'd11, 3'd3, 1'b0, NINF, PINF, ONE,  1'b1, DNAN, 1'b1}, // R11
    '{4'd11, 3'd3, 1'b0, ONE,  NINF, ONE,  1'b1, NINF, 1'b0}, // R11
    '{4'd11, 3'd4, 1'b0, ONE,  ONE,  NINF, 1'b1, PINF, 1'b0}, // R11
    '{4'd12, 3'd0, 1'b0, ONE,  ONE,  S1,   1'b0, ZERO, 1'b0}, // R12
    '{4'd12, 3'd2, 1'b0, ONE,  ONE,  Q1,   1'b0, ZERO, 1'b0}  // R12
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic        legacy_i = 1'b0;
  logic [31:0] opnd_a_i = '0, opnd_b_i = '0, opnd_c_i = '0;
  logic        bypass_o, invalid_o;
  logic [31:0] result_o;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #2 clk = ~clk;

  fpsr_special_resolve dut (
    .op_i      (op_i),
    .legacy_i  (legacy_i),
    .opnd_a_i  (opnd_a_i),
    .opnd_b_i  (opnd_b_i),
    .opnd_c_i  (opnd_c_i),
    .bypass_o  (bypass_o),
    .result_o  (result_o),
    .invalid_o (invalid_o)
  );

  // drive on falling edge, sample 1 ns later: result is same-cycle
  task automatic apply_check(input string tag, input logic [2:0] op, input logic leg,
                             input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                             input logic e_byp, input logic [31:0] e_res, input logic e_inv);
    @(negedge clk);
    op_i = op; legacy_i = leg; opnd_a_i = a; opnd_b_i = b; opnd_c_i = c;
    #1;
    n_tests++;
    if (bypass_o !== e_byp || result_o !== e_res || invalid_o !== e_inv) begin
      n_fail++;
      $display("FAIL %s op=%0d leg=%0d a=%h b=%h c=%h: got byp=%b res=%h inv=%b exp byp=%b res=%h inv=%b",
               tag, op, leg, a, b, c, bypass_o, result_o, invalid_o, e_byp, e_res, e_inv);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // R1: idle inputs during reset give all-zero outputs
    apply_check("R1 reset", 3'd0, 1'b0, ZERO, ZERO, ZERO, 1'b0, ZERO, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply_check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].op, VECS[i].leg,
                  VECS[i].a, VECS[i].b, VECS[i].c, VECS[i].byp, VECS[i].res, VECS[i].inv);
    end

    // R2: unused opcodes ignore NaN operands in both policies
    for (int op = 5; op < 8; op++) begin
      apply_check("R2 unused opcode", 3'(op), 1'b0, Q1, S1, Q2, 1'b0, ZERO, 1'b0);
      apply_check("R2 unused opcode", 3'(op), 1'b1, S1, Q1, Q2, 1'b0, ZERO, 1'b0);
    end

    // R10: legacy never flags, signaling NaN everywhere
    for (int op = 0; op < 5; op++) begin
      apply_check("R10 legacy flag", 3'(op), 1'b1, S2, S1, S1, 1'b1,
                  (op >= 3) ? S1 : S2, 1'b0);
    end

    // R12: third operand varied, two-operand result unchanged
    apply_check("R12 c ignored", 3'd1, 1'b0, ONE, PINF, Q3, 1'b1, NINF, 1'b0);
    apply_check("R12 c ignored", 3'd2, 1'b0, PINF, ZERO, NINF, 1'b1, DNAN, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule